// File: doc/BRIEF.md
# Four-Line Latched LCD Polarity Driver

This block drives four independent display lines of a liquid-crystal panel, for example a decimal point, a colon or a sign indicator. The lines use the same polarity scheme as a digit decoder elsewhere on the chip. Each line has a data bit that marks it selected (1) or not selected (0). Each line also has a strobe of its own, and a level-enabled clocked latch holds that line's selection. A single display-frequency input `df_in` is shared by all four lines. Each output is the held selection combined with `df_in` by exclusive-OR.

When `df_in` carries a square wave, a selected line toggles in antiphase with it and an unselected line toggles in phase with it. The liquid crystal therefore sees an AC voltage only across selected segments. If a line's data is tied low and its strobe high, that output is a copy of `df_in`, and it can then drive the panel's common electrode.

Every output is registered. Each output reflects the strobe, data and `df_in` values sampled at one rising clock edge, and is visible after that edge. Line index i is bit i of each vector port.

Top module: `lcd_quad_line_driver`

## Requirements
- R1: While `rst_n` is low, all bits of `line_drv` are 0. Every latch returns to 0 (not selected).
- R2: At a rising edge where `line_stb[i]` is 1, the latch of line i takes `line_din[i]`.
- R3: At a rising edge where `line_stb[i]` is 0, the latch of line i keeps its value, whatever `line_din[i]` does.
- R4: A selected line (latch 1) sampled together with `df_in` = 0 gives `line_drv[i]` = 1 after that edge.
- R5: A selected line sampled together with `df_in` = 1 gives `line_drv[i]` = 0 after that edge.
- R6: An unselected line (latch 0) gives `line_drv[i]` equal to the `df_in` sampled at the same edge. With a square wave on `df_in`, the line is in phase with it, and a selected line is in antiphase.
- R7: A strobe on one line does not change the latch of any other line.
- R8: One `df_in` controls all four lines. A line held with data 0 and strobe 1 reproduces `df_in` with one cycle of delay, for use as the common-electrode drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_din | input | 4 | Selection data, one bit per line |
| line_stb | input | 4 | Level strobe per line; 1 loads, 0 holds |
| df_in | input | 1 | Shared display-frequency / polarity control |
| line_drv | output | 4 | Registered drive level per line |

## Verification
The properties assume that `df_in`, `line_stb` and `line_din` are synchronous to `clk` and are defined at every rising edge after reset. The hold and load properties also assume that at least one edge has passed since reset, so that the previous `df_in` is known. The stimulus changes all inputs only on the falling clock edge, and it releases reset before the first checked edge. It runs `df_in` both as a static level and as a square wave, and it pulses single strobes while the data of the other lines toggles.

// File: rtl/lcd_quad_line_pkg.sv
package lcd_quad_line_pkg;

    // Polarity rule: a held selection inverts the display-frequency level.
    function automatic logic seg_level(input logic held, input logic dfreq);
        return held ^ dfreq;
    endfunction

endpackage

// File: rtl/lcd_line_hold.sv
module lcd_line_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic held_d,
    output logic held_q
);
    typedef struct packed {
        logic held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.held = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_d = st_d.held;
    assign held_q = st_q.held;
endmodule

// File: rtl/lcd_polarity_stage.sv
module lcd_polarity_stage #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] held_next,
    input  logic             dfreq,
    output logic [LINES-1:0] drv_q
);
    import lcd_quad_line_pkg::*;

    typedef struct packed {
        logic [LINES-1:0] drv;
    } pol_state_t;

    pol_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LINES; k++) begin
            st_d.drv[k] = seg_level(held_next[k], dfreq);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_q = st_q.drv;
endmodule

// File: rtl/lcd_quad_line_driver.sv
module lcd_quad_line_driver #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_din,
    input  logic [LINES-1:0] line_stb,
    input  logic             df_in,
    output logic [LINES-1:0] line_drv
);
    logic [LINES-1:0] held_next;
    logic [LINES-1:0] held_now;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        lcd_line_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (line_stb[g]),
            .din    (line_din[g]),
            .held_d (held_next[g]),
            .held_q (held_now[g])
        );
    end

    lcd_polarity_stage #(.LINES(LINES)) u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .held_next (held_next),
        .dfreq     (df_in),
        .drv_q     (line_drv)
    );

    logic unused_held;
    assign unused_held = ^held_now;
endmodule

// File: rtl/lcd_quad_line_driver_chk.sv
module lcd_quad_line_driver_chk #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] line_din,
    input logic [LINES-1:0] line_stb,
    input logic             df_in,
    input logic [LINES-1:0] line_drv
);
    logic seen_q;
    logic df_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            df_q   <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            df_q   <= df_in;
        end
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |-> line_drv == '0); // R1

    for (genvar g = 0; g < LINES; g++) begin : g_chk
        AST_LOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            line_stb[g] |=> line_drv[g] == ($past(line_din[g]) ^ $past(df_in))); // R2

        AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && !line_stb[g]) |=>
            ((line_drv[g] ^ df_q) == $past(line_drv[g] ^ df_q))); // R3

        AST_COMMON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (line_stb[g] && !line_din[g]) |=> line_drv[g] == $past(df_in)); // R8
    end
endmodule

bind lcd_quad_line_driver lcd_quad_line_driver_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_din (line_din),
    .line_stb (line_stb),
    .df_in    (df_in),
    .line_drv (line_drv)
);

// File: tb/tb_lcd_quad_line_driver.sv
module tb_lcd_quad_line_driver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [3:0] line_din = '0;
    logic [3:0] line_stb = '0;
    logic       df_in = 1'b0;
    logic [3:0] line_drv;

    int checks = 0;
    int errors = 0;
    int model_sel [4];
    int model_drv [4];

    always #2 clk = ~clk;

    lcd_quad_line_driver dut (
        .clk(clk), .rst_n(rst_n), .line_din(line_din),
        .line_stb(line_stb), .df_in(df_in), .line_drv(line_drv)
    );

    task automatic check_bit(input string tag, input int idx, input logic got, input int exp);
        checks++;
        if (got !== exp[0]) begin
            errors++;
            $display("FAIL %s line %0d: actual %b expected %0d", tag, idx, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < 4; i++) check_bit(tag, i, line_drv[i], model_drv[i]);
    endtask

    // Called at a falling edge: apply inputs, model the rising edge, compare at the next fall.
    task automatic step(input logic [3:0] stb, input logic [3:0] din, input logic df, input string tag);
        line_stb = stb;
        line_din = din;
        df_in    = df;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (stb[i]) model_sel[i] = din[i] ? 1 : 0;
            model_drv[i] = (model_sel[i] != 0) != df ? 1 : 0;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            model_sel[i] = 0;
            model_drv[i] = 0;
        end
        repeat (2) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        apply_reset();
        // R6: unselected lines follow df
        step(4'b0000, 4'b1111, 1'b1, "R6");
        step(4'b0000, 4'b1111, 1'b0, "R6");
        // R2 / R4: load selections with df low
        step(4'b1111, 4'b1010, 1'b0, "R2");
        step(4'b1111, 4'b0101, 1'b0, "R4");
        // R5: df high inverts selected lines
        step(4'b0000, 4'b0000, 1'b1, "R5");
        // R3: strobes low, data changes, no effect
        step(4'b0000, 4'b1010, 1'b1, "R3");
        step(4'b0000, 4'b1111, 1'b0, "R3");
        // R6: square wave, antiphase and in-phase lines
        for (int k = 0; k < 8; k++) step(4'b0000, 4'b0000, k[0], "R6");
        // R7: strobe one line at a time, other data toggled
        for (int j = 0; j < 4; j++) begin
            step(4'b0001 << j, ~line_din, 1'b0, "R7");
            step(4'b0001 << j, 4'b1111, 1'b1, "R7");
        end
        // R8: line 0 as common-electrode copy of df
        for (int k = 0; k < 6; k++) step(4'b0001, 4'b1110, k[1], "R8");
        // R1: reset again after activity
        @(negedge clk);
        apply_reset();
        step(4'b0000, 4'b1111, 1'b1, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule